// File: doc/BRIEF.md
# State-of-Charge LED Bar Driver

This block turns a remaining-charge count into a five-LED bar for a battery pack. Each LED stands for one fifth of a full-scale reference. Software picks that reference with a mode input: the learned capacity in relative mode, or the programmed count in absolute mode. The LEDs are multiplexed in two interleaved banks at a low duty cycle. Segment 1 blinks when the battery is low. The final empty flag blanks the whole bar. A test register can take over the five segments directly.

The display is lit while a request input is held, and for a fixed hold time after it is released. It is also lit while a charge-activity condition is present, and while a heavy-discharge condition is present plus a longer hold after that condition ends. A disable input keeps it dark. The block also supplies a 4-bit gauge in sixteenths of the reference for a status register. All timing comes from one free-running divider: a prescaler, then a step counter that forms the bank frame, then frame-based blink and hold counters.

Top module: `soc_bar_driver`

## Requirements
- R1: Segment n (n = 1..5, driven on bit n-1 of `seg_n`) is part of the bar when remain×5 ≥ n×reference, using exact integer arithmetic with no rounding up. A zero reference lights all five.
- R2: The reference is `prog_cap` when `mode_abs` is 1 and `learned_cap` when it is 0.
- R3: Segments 1, 3 and 5 light only in the first half of each frame. Segments 2 and 4 light only in the second half. The two groups are never lit in the same cycle. In each half, a lit segment is on for ON_STEPS of the HALF_STEPS prescaled steps.
- R4: When `edv1` is 1, or when remain×10 < reference, segment 1 is lit only during alternate runs of BLINK_HALF_FRAMES frames. Over a full blink period it is on for half as many cycles as the other segments.
- R5: While `edvf` is 1, all five segments are off (`seg_n` all ones), from the cycle after it is seen.
- R6: While `disp_req` is 1 the display is active. After release it stays active for REQ_HOLD_FRAMES frames, within one frame.
- R7: While `disp_off` is 1, and no override is active, `lcom` is 0 and all segments are off.
- R8: While `chg_bright` is 1 the display is active. It goes dark the cycle after the condition drops, if no other source holds it on.
- R9: While `dsg_heavy` is 1 the display is active. After it ends, the display stays active for DSG_HOLD_FRAMES frames, within one frame.
- R10: While `ovr_en` is 1, the cycle after holds `seg_n` = ~`ovr_seg` and `lcom` = 1. This takes precedence over disable, the empty flags, blinking and multiplexing.
- R11: `gauge` equals floor(remain×16 / reference), saturated at 15, and is 15 for a zero reference. It is registered with one cycle of latency.
- R12: Outside override, no segment is lit in a cycle where `lcom` is 0.
- R13: During reset, `seg_n` is all ones, and `lcom` and `gauge` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_abs | input | 1 | 1 = absolute (programmed reference), 0 = relative (learned reference) |
| learned_cap | input | CW | Learned capacity |
| prog_cap | input | CW | Programmed full count |
| remain | input | CW | Remaining charge count |
| disp_req | input | 1 | Display request, active high |
| disp_off | input | 1 | Display disable |
| chg_bright | input | 1 | Charge activity above display threshold |
| dsg_heavy | input | 1 | Discharge activity beyond display threshold |
| edv1 | input | 1 | First end-of-discharge flag |
| edvf | input | 1 | Final end-of-discharge flag |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 5 | Override segment values, 1 = lit |
| seg_n | output | 5 | Segment drives, active low, bit 0 = segment 1 |
| lcom | output | 1 | LED common enable, active high |
| gauge | output | 4 | Remaining fraction in sixteenths |

## Verification
Every remain value of an 8-bit count is swept against three references: a large learned value in relative mode, a small programmed value in absolute mode, and a zero reference. Each point is observed over one full blink period. Per-segment on-cycle counts separate threshold errors, mode-select errors, bank-assignment and duty errors, and a missing or stray low-battery blink, because a blinking segment shows exactly half the count. Separate runs cover each display source: the request hold, the charge condition, and the discharge hold, each probed just inside and just outside its hold window. Further runs cover disable, the two empty flags, and all 32 override patterns set up against disable and the final empty flag.

// File: rtl/soc_bar_pkg.sv
package soc_bar_pkg;
  localparam int SEG_COUNT = 5;
  localparam int GAUGE_STEPS = 16;

  typedef enum logic { BANK_ODD = 1'b0, BANK_EVEN = 1'b1 } bank_e;

  // segment index 0 is segment 1; odd-numbered segments share the first slot
  function automatic bank_e bank_of(input int idx);
    return (idx % 2 == 0) ? BANK_ODD : BANK_EVEN;
  endfunction
endpackage

// File: rtl/soc_bar_timebase.sv
module soc_bar_timebase #(
  parameter int PRE_DIV           = 1000,
  parameter int HALF_STEPS        = 10,
  parameter int ON_STEPS          = 3,
  parameter int BLINK_HALF_FRAMES = 40
) (
  input  logic clk,
  input  logic rst_n,
  output logic frame_tick,
  output logic slot_odd_on,
  output logic slot_even_on,
  output logic blink_on
);
  localparam int FRAME = 2 * HALF_STEPS;
  localparam int PW = $clog2(PRE_DIV + 1);
  localparam int SW = $clog2(FRAME + 1);
  localparam int BW = $clog2(BLINK_HALF_FRAMES + 1);
  localparam logic [PW-1:0] PRE_LAST   = PW'(PRE_DIV - 1);
  localparam logic [SW-1:0] STEP_LAST  = SW'(FRAME - 1);
  localparam logic [SW-1:0] ON_L       = SW'(ON_STEPS);
  localparam logic [SW-1:0] HALF_L     = SW'(HALF_STEPS);
  localparam logic [SW-1:0] EVEN_END   = SW'(HALF_STEPS + ON_STEPS);
  localparam logic [BW-1:0] BLINK_LAST = BW'(BLINK_HALF_FRAMES - 1);

  logic [PW-1:0] pre_cnt;
  logic [SW-1:0] step_cnt;
  logic [BW-1:0] blink_cnt;
  logic          step_tick;

  assign step_tick  = (pre_cnt == PRE_LAST);
  assign frame_tick = step_tick && (step_cnt == STEP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      step_cnt  <= '0;
      blink_cnt <= '0;
      blink_on  <= 1'b1;
    end else begin
      pre_cnt <= step_tick ? '0 : pre_cnt + 1'b1;
      if (step_tick) step_cnt <= (step_cnt == STEP_LAST) ? '0 : step_cnt + 1'b1;
      if (frame_tick) begin
        if (blink_cnt == BLINK_LAST) begin
          blink_cnt <= '0;
          blink_on  <= ~blink_on;
        end else begin
          blink_cnt <= blink_cnt + 1'b1;
        end
      end
    end
  end

  assign slot_odd_on  = (step_cnt < ON_L);
  assign slot_even_on = (step_cnt >= HALF_L) && (step_cnt < EVEN_END);
endmodule

// File: rtl/soc_bar_level.sv
module soc_bar_level #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] remain,
  input  logic [CW-1:0] ref_cnt,
  output logic [4:0]    lit,
  output logic          low_batt,
  output logic [3:0]    gauge
);
  localparam int PW = CW + 4;

  // true when num*nmul >= den*dmul, computed wide enough not to wrap
  function automatic logic frac_ge(input logic [CW-1:0] num, input logic [CW-1:0] den,
                                   input int unsigned nmul, input int unsigned dmul);
    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;
    lhs = PW'(num) * PW'(nmul);
    rhs = PW'(den) * PW'(dmul);
    return lhs >= rhs;
  endfunction

  for (genvar g = 0; g < soc_bar_pkg::SEG_COUNT; g++) begin : g_seg
    assign lit[g] = frac_ge(remain, ref_cnt, 5, g + 1);
  end

  assign low_batt = !frac_ge(remain, ref_cnt, 10, 1);

  logic [soc_bar_pkg::GAUGE_STEPS-2:0] ge16;
  for (genvar k = 1; k < soc_bar_pkg::GAUGE_STEPS; k++) begin : g_gauge
    assign ge16[k-1] = frac_ge(remain, ref_cnt, soc_bar_pkg::GAUGE_STEPS, k);
  end

  always_comb begin
    gauge = '0;
    for (int i = 0; i < soc_bar_pkg::GAUGE_STEPS - 1; i++) gauge = gauge + 4'(ge16[i]);
  end
endmodule

// File: rtl/soc_bar_activity.sv
module soc_bar_activity #(
  parameter int REQ_HOLD_FRAMES = 1280,
  parameter int DSG_HOLD_FRAMES = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic disp_req,
  input  logic disp_off,
  input  logic chg_bright,
  input  logic dsg_heavy,
  output logic disp_active
);
  localparam int RW = $clog2(REQ_HOLD_FRAMES + 1);
  localparam int DW = $clog2(DSG_HOLD_FRAMES + 1);
  localparam logic [RW-1:0] REQ_LOAD = RW'(REQ_HOLD_FRAMES);
  localparam logic [DW-1:0] DSG_LOAD = DW'(DSG_HOLD_FRAMES);

  logic [RW-1:0] req_hold;
  logic [DW-1:0] dsg_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_hold <= '0;
      dsg_hold <= '0;
    end else begin
      if (disp_req) req_hold <= REQ_LOAD;
      else if (frame_tick && req_hold != '0) req_hold <= req_hold - 1'b1;
      if (dsg_heavy) dsg_hold <= DSG_LOAD;
      else if (frame_tick && dsg_hold != '0) dsg_hold <= dsg_hold - 1'b1;
    end
  end

  assign disp_active = !disp_off &&
                       (disp_req || chg_bright || dsg_heavy || req_hold != '0 || dsg_hold != '0);
endmodule

// File: rtl/soc_bar_driver.sv
module soc_bar_driver #(
  parameter int CW                = 16,
  parameter int PRE_DIV           = 1000,
  parameter int HALF_STEPS        = 10,
  parameter int ON_STEPS          = 3,
  parameter int BLINK_HALF_FRAMES = 40,
  parameter int REQ_HOLD_FRAMES   = 1280,
  parameter int DSG_HOLD_FRAMES   = 3200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_abs,
  input  logic [CW-1:0] learned_cap,
  input  logic [CW-1:0] prog_cap,
  input  logic [CW-1:0] remain,
  input  logic          disp_req,
  input  logic          disp_off,
  input  logic          chg_bright,
  input  logic          dsg_heavy,
  input  logic          edv1,
  input  logic          edvf,
  input  logic          ovr_en,
  input  logic [4:0]    ovr_seg,
  output logic [4:0]    seg_n,
  output logic          lcom,
  output logic [3:0]    gauge
);
  import soc_bar_pkg::*;

  logic          frame_tick, slot_odd_on, slot_even_on, blink_on;
  logic          disp_active, low_batt, blink_need;
  logic [CW-1:0] ref_cnt;
  logic [4:0]    lit, seg_on;
  logic [3:0]    gauge_c;
  logic          ovr_act_q;

  soc_bar_timebase #(
    .PRE_DIV(PRE_DIV), .HALF_STEPS(HALF_STEPS), .ON_STEPS(ON_STEPS),
    .BLINK_HALF_FRAMES(BLINK_HALF_FRAMES)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .slot_odd_on(slot_odd_on), .slot_even_on(slot_even_on), .blink_on(blink_on)
  );

  assign ref_cnt = mode_abs ? prog_cap : learned_cap;

  soc_bar_level #(.CW(CW)) u_lvl (
    .remain(remain), .ref_cnt(ref_cnt), .lit(lit), .low_batt(low_batt), .gauge(gauge_c)
  );

  soc_bar_activity #(
    .REQ_HOLD_FRAMES(REQ_HOLD_FRAMES), .DSG_HOLD_FRAMES(DSG_HOLD_FRAMES)
  ) u_act (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .disp_req(disp_req),
    .disp_off(disp_off), .chg_bright(chg_bright), .dsg_heavy(dsg_heavy),
    .disp_active(disp_active)
  );

  assign blink_need = edv1 || low_batt;

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_drive
    logic slot_ok;
    logic blink_ok;
    assign slot_ok  = (bank_of(i) == BANK_ODD) ? slot_odd_on : slot_even_on;
    if (i == 0) begin : g_first
      assign blink_ok = !blink_need || blink_on;
    end else begin : g_rest
      assign blink_ok = 1'b1;
    end
    assign seg_on[i] = disp_active && !edvf && lit[i] && slot_ok && blink_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_n     <= '1;
      lcom      <= 1'b0;
      gauge     <= '0;
      ovr_act_q <= 1'b0;
    end else begin
      gauge     <= gauge_c;
      ovr_act_q <= ovr_en;
      if (ovr_en) begin
        seg_n <= ~ovr_seg;
        lcom  <= 1'b1;
      end else begin
        seg_n <= ~seg_on;
        lcom  <= disp_active;
      end
    end
  end
endmodule

// File: rtl/soc_bar_driver_chk.sv
module soc_bar_driver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovr_en,
  input logic [4:0] ovr_seg,
  input logic       edvf,
  input logic       disp_off,
  input logic       disp_req,
  input logic       chg_bright,
  input logic [4:0] seg_n,
  input logic       lcom,
  input logic       ovr_act_q
);
  assert_banks_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_act_q |-> !((|(~seg_n & 5'b10101)) && (|(~seg_n & 5'b01010))));

  assert_final_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edvf && !ovr_en) |=> (seg_n == 5'b11111));

  assert_request_lights_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_req && !disp_off && !ovr_en) |=> lcom);

  assert_disable_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off && !ovr_en) |=> (!lcom && seg_n == 5'b11111));

  assert_charge_lights_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_bright && !disp_off && !ovr_en) |=> lcom);

  assert_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en |=> (seg_n == ~$past(ovr_seg) && lcom));

  assert_dark_common_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcom && !ovr_act_q) |-> (seg_n == 5'b11111));
endmodule

bind soc_bar_driver soc_bar_driver_chk u_chk (.*);

// File: tb/soc_bar_driver_tb.sv
module soc_bar_driver_tb;
  localparam int CLK_P = 10;
  localparam int CW = 8;
  localparam int PRE = 2, HALF = 5, ON = 2, BLH = 2, REQH = 4, DSGH = 6;
  localparam int FRAME_CYC = 2 * HALF * PRE;
  localparam int WIN = 2 * BLH * FRAME_CYC;
  localparam int FULL_ON = (WIN / FRAME_CYC) * ON * PRE;

  logic clk = 0, rst_n = 0;
  logic mode_abs = 0, disp_req = 0, disp_off = 0, chg_bright = 0, dsg_heavy = 0;
  logic edv1 = 0, edvf = 0, ovr_en = 0;
  logic [CW-1:0] learned_cap = 0, prog_cap = 0, remain = 0;
  logic [4:0] ovr_seg = 0, seg_n;
  logic lcom;
  logic [3:0] gauge;

  int total = 0, bad = 0;
  int seg_cnt[5];
  int lcom_cnt, overlap, dark_lit = 0;
  bit done = 0;

  soc_bar_driver #(.CW(CW), .PRE_DIV(PRE), .HALF_STEPS(HALF), .ON_STEPS(ON),
    .BLINK_HALF_FRAMES(BLH), .REQ_HOLD_FRAMES(REQH), .DSG_HOLD_FRAMES(DSGH)) u_dut (.*);

  always #(CLK_P / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic observe(input int n);
    for (int i = 0; i < 5; i++) seg_cnt[i] = 0;
    lcom_cnt = 0;
    overlap = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int i = 0; i < 5; i++) if (!seg_n[i]) seg_cnt[i]++;
      if (lcom) lcom_cnt++;
      if ((!seg_n[0] || !seg_n[2] || !seg_n[4]) && (!seg_n[1] || !seg_n[3])) overlap++;
      if (!lcom && seg_n != 5'b11111) dark_lit++;
    end
  endtask

  // expected per-segment counts from the stated arithmetic
  task automatic sweep(input bit abs_m, input int lrn, input int prg);
    int rf;
    mode_abs = abs_m; learned_cap = CW'(lrn); prog_cap = CW'(prg);
    rf = abs_m ? prg : lrn;
    for (int r = 0; r < 256; r++) begin
      int exp_cnt[5];
      int exp_g;
      bit lowb, ok;
      remain = CW'(r);
      settle();
      observe(WIN);
      lowb = (r * 10 < rf);
      for (int n = 1; n <= 5; n++) begin
        bit on;
        on = (n * rf <= 5 * r);
        exp_cnt[n-1] = !on ? 0 : ((n == 1 && lowb) ? FULL_ON / 2 : FULL_ON);
      end
      exp_g = (rf == 0) ? 15 : ((r * 16) / rf > 15 ? 15 : (r * 16) / rf);
      ok = 1;
      for (int i = 0; i < 5; i++) if (seg_cnt[i] != exp_cnt[i]) ok = 0;
      check(ok && overlap == 0, "R1 R2 R3 R4",
        $sformatf("ref=%0d remain=%0d got %0d/%0d/%0d/%0d/%0d ovl=%0d exp %0d/%0d/%0d/%0d/%0d ovl=0",
          rf, r, seg_cnt[0], seg_cnt[1], seg_cnt[2], seg_cnt[3], seg_cnt[4], overlap,
          exp_cnt[0], exp_cnt[1], exp_cnt[2], exp_cnt[3], exp_cnt[4]));
      check(gauge == 4'(exp_g), "R11",
        $sformatf("ref=%0d remain=%0d gauge got %0d exp %0d", rf, r, gauge, exp_g));
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R13 reset state
    repeat (3) @(negedge clk);
    check(seg_n == 5'b11111 && !lcom && gauge == 0, "R13",
      $sformatf("reset seg_n=%b lcom=%b gauge=%0d exp 11111 0 0", seg_n, lcom, gauge));
    rst_n = 1;
    disp_req = 1;

    sweep(0, 200, 90);
    sweep(1, 200, 37);
    sweep(0, 0, 90);

    // R4 blink by first empty flag with a full bar
    mode_abs = 0; learned_cap = 200; remain = 200; edv1 = 1;
    settle(); observe(WIN);
    check(seg_cnt[0] == FULL_ON / 2 && seg_cnt[4] == FULL_ON, "R4",
      $sformatf("edv1 seg1=%0d seg5=%0d exp %0d %0d", seg_cnt[0], seg_cnt[4], FULL_ON / 2, FULL_ON));
    edv1 = 0;

    // R5 final empty blanks all
    edvf = 1; settle(); observe(WIN);
    check(seg_cnt[0] + seg_cnt[1] + seg_cnt[2] + seg_cnt[3] + seg_cnt[4] == 0 && lcom_cnt == WIN, "R5",
      $sformatf("edvf lit=%0d lcom=%0d exp 0 %0d",
        seg_cnt[0] + seg_cnt[1] + seg_cnt[2] + seg_cnt[3] + seg_cnt[4], lcom_cnt, WIN));
    edvf = 0;

    // R7 disable wins over request
    disp_off = 1; settle(); observe(WIN);
    check(seg_cnt[0] + seg_cnt[2] + seg_cnt[4] == 0 && lcom_cnt == 0, "R7",
      $sformatf("disable lit=%0d lcom=%0d exp 0 0", seg_cnt[0] + seg_cnt[2] + seg_cnt[4], lcom_cnt));
    disp_off = 0;

    // R6 request hold after release
    settle();
    disp_req = 0;
    repeat ((REQH - 1) * FRAME_CYC) @(negedge clk);
    check(lcom == 1, "R6", $sformatf("inside hold lcom=%b exp 1", lcom));
    repeat (FRAME_CYC + 3) @(negedge clk);
    check(lcom == 0, "R6", $sformatf("after hold lcom=%b exp 0", lcom));

    // R8 charge activity, no hold
    chg_bright = 1; settle();
    check(lcom == 1, "R8", $sformatf("charge lcom=%b exp 1", lcom));
    chg_bright = 0; settle();
    check(lcom == 0, "R8", $sformatf("charge released lcom=%b exp 0", lcom));

    // R9 discharge hold
    dsg_heavy = 1; settle();
    check(lcom == 1, "R9", $sformatf("discharge lcom=%b exp 1", lcom));
    dsg_heavy = 0;
    repeat ((DSGH - 1) * FRAME_CYC) @(negedge clk);
    check(lcom == 1, "R9", $sformatf("inside discharge hold lcom=%b exp 1", lcom));
    repeat (FRAME_CYC + 3) @(negedge clk);
    check(lcom == 0, "R9", $sformatf("after discharge hold lcom=%b exp 0", lcom));

    // R10 override over every pattern, against disable and final empty
    disp_off = 1; edvf = 1; ovr_en = 1;
    for (int v = 0; v < 32; v++) begin
      ovr_seg = 5'(v);
      settle();
      check(seg_n == ~5'(v) && lcom == 1, "R10",
        $sformatf("ovr=%0d seg_n=%b lcom=%b exp %b 1", v, seg_n, lcom, ~5'(v)));
    end
    ovr_en = 0; disp_off = 0; edvf = 0;
    settle(); observe(FRAME_CYC);

    // R12 no lit segment with common off, over all observed cycles
    check(dark_lit == 0, "R12", $sformatf("lit while dark=%0d exp 0", dark_lit));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule